// File: doc/BRIEF.md
# Management Serial Port Slave

This block is the target side of a two-wire management bus on a physical-layer device. The host supplies a serial clock and uses a single shared data line. The block runs entirely on that serial clock. It waits for a preamble of ones, then decodes the start pattern, a pair of read/write flags, a five-bit device address and a five-bit register address. After the turnaround it moves sixteen data bits, either into the device or out to the host.

A small internal port sits on the device side. The block raises a one-cycle read strobe and captures the returned word, or raises a one-cycle write strobe carrying the assembled word. Eleven registers (addresses 0 to 10) exist. The device address is matched against the bitwise inverse of the address straps. Those straps are captured while reset is held.

Top module: `mgmt_serial_slave`

## Requirements
- R1: While and after reset, `md_oe`, `reg_rd` and `reg_wr` are low until a valid frame calls for them.
- R2: A frame is recognised only after at least 32 consecutive ones are sampled on `md_in`. With only 31 ones before the start pattern, the frame has no effect.
- R3: The two bits that follow the preamble must be 0 then 1. Any other pair abandons the frame, with no strobe and no drive.
- R4: The next two bits are a read flag and then a write flag (1 = selected). Exactly one of them must be set. Both set or neither set abandons the frame.
- R5: The next five bits, most significant first, are the device address. The frame proceeds only if this address equals the bitwise inverse of `strap_n` as sampled on clock edges while `rst_n` is low. Later changes on `strap_n` have no effect.
- R6: On a read, the next five bits are the register address. During the first turnaround bit, `reg_rd` is high for one cycle with `reg_addr` set, but only for addresses 0 to 10. `md_oe` stays low during that bit. During the second turnaround bit the block drives 0.
- R7: On a read, the 16 data bits are driven most significant first. Each bit is updated on the rising edge that ends the previous bit. `md_oe` drops on the rising edge that ends the last data bit. Addresses 11 to 31 return zero.
- R8: On a write, 16 data bits are taken most significant first. After the rising edge of the last bit, `reg_wr` pulses for one cycle with `reg_addr` and `reg_wdata`. There is no pulse for addresses above 10.
- R9: After every frame, complete or abandoned, a fresh preamble of 32 ones is needed. A frame sent immediately afterwards is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Serial clock from the host; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| strap_n | input | 5 | Address strap pins, inverted sense |
| md_in | input | 1 | Sampled value of the shared data line |
| md_out | output | 1 | Value to drive onto the data line |
| md_oe | output | 1 | Drive enable for the data line |
| reg_addr | output | 5 | Register address for the internal port |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data, valid while `reg_rd` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Write data, valid while `reg_wr` is high |

## Verification
Frame bits are counted from the first start bit as bit 0, and each bit ends on a rising edge. The read strobe is therefore due during bit 14. The turnaround zero is due during bit 15. Read data bit k is due during bit 16+k, and the write strobe is due in the cycle after the edge that ends bit 31. The bench drives `md_in` and samples every output at the falling edge inside each bit, so each check reads the value registered at the preceding rising edge. For abandoned frames it checks every bit for drive and strobes, and it checks the cycle after the frame for a write.

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave #(
  parameter int NUM_REGS = 11,
  parameter int AW       = 5,
  parameter int DW       = 16,
  parameter int PRE_LEN  = 32
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_n,
  input  logic          md_in,
  output logic          md_out,
  output logic          md_oe,
  output logic [AW-1:0] reg_addr,
  output logic          reg_rd,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata
);
  localparam int CW = $clog2(DW);
  localparam int PW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] AEND  = CW'(AW - 1);
  localparam logic [CW-1:0] DEND  = CW'(DW - 1);
  localparam logic [PW-1:0] PFULL = PW'(PRE_LEN);
  localparam logic [AW-1:0] LAST  = AW'(NUM_REGS - 1);

  typedef enum logic [3:0] {
    S_HUNT, S_ST1, S_RDF, S_WRF, S_PHY, S_REG, S_TA1, S_TA2, S_DATA
  } st_t;

  st_t           state;
  logic [PW-1:0] pre_cnt;
  logic [CW-1:0] bcnt;
  logic          is_rd;
  logic [AW-1:0] phy_sh, reg_a, strap_q;
  logic [DW-1:0] dsh;
  logic          out_q, oe_q, rd_q, wr_q;

  wire [AW-1:0] phy_nx = {phy_sh[AW-2:0], md_in};
  wire [AW-1:0] reg_nx = {reg_a[AW-2:0], md_in};

  assign md_out    = out_q;
  assign md_oe     = oe_q;
  assign reg_addr  = reg_a;
  assign reg_rd    = rd_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = dsh;

  always_ff @(posedge mdc)
    if (!rst_n) strap_q <= strap_n;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_HUNT;
      pre_cnt <= '0;
      bcnt    <= '0;
      is_rd   <= 1'b0;
      phy_sh  <= '0;
      reg_a   <= '0;
      dsh     <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      case (state)
        S_HUNT:
          if (md_in) begin
            if (pre_cnt != PFULL) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            pre_cnt <= '0;
            if (pre_cnt == PFULL) state <= S_ST1;
          end
        S_ST1: state <= md_in ? S_RDF : S_HUNT;
        S_RDF: begin
          is_rd <= md_in;
          state <= S_WRF;
        end
        S_WRF: begin
          bcnt  <= '0;
          state <= (is_rd ^ md_in) ? S_PHY : S_HUNT;
        end
        S_PHY: begin
          phy_sh <= phy_nx;
          bcnt   <= bcnt + 1'b1;
          if (bcnt == AEND) begin
            bcnt  <= '0;
            state <= (phy_nx == ~strap_q) ? S_REG : S_HUNT;
          end
        end
        S_REG: begin
          reg_a <= reg_nx;
          bcnt  <= bcnt + 1'b1;
          if (bcnt == AEND) begin
            bcnt  <= '0;
            state <= S_TA1;
            rd_q  <= is_rd && (reg_nx <= LAST);
          end
        end
        S_TA1: begin
          state <= S_TA2;
          if (is_rd) begin
            dsh   <= (reg_a <= LAST) ? reg_rdata : '0;
            oe_q  <= 1'b1;
            out_q <= 1'b0;
          end
        end
        S_TA2: begin
          state <= S_DATA;
          bcnt  <= '0;
          if (is_rd) begin
            out_q <= dsh[DW-1];
            dsh   <= {dsh[DW-2:0], 1'b0};
          end
        end
        S_DATA: begin
          bcnt <= bcnt + 1'b1;
          if (is_rd) begin
            out_q <= dsh[DW-1];
            dsh   <= {dsh[DW-2:0], 1'b0};
          end else begin
            dsh <= {dsh[DW-2:0], md_in};
          end
          if (bcnt == DEND) begin
            state   <= S_HUNT;
            pre_cnt <= '0;
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
            wr_q    <= !is_rd && (reg_a <= LAST);
          end
        end
        default: state <= S_HUNT;
      endcase
    end
  end
endmodule

module mgmt_serial_slave_chk #(
  parameter int NUM_REGS = 11,
  parameter int AW       = 5
) (
  input logic          mdc,
  input logic          rst_n,
  input logic          md_out,
  input logic          md_oe,
  input logic [AW-1:0] reg_addr,
  input logic          reg_rd,
  input logic          reg_wr
);
  a_r6_rd_then_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |=> (md_oe && !md_out));
  a_r6_first_drive_zero: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(md_oe) |-> !md_out);
  a_r6_rd_single: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  a_r6_rd_in_range: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |-> (reg_addr < AW'(NUM_REGS)));
  a_r8_wr_single: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r8_wr_in_range: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr |-> (reg_addr < AW'(NUM_REGS)));
  a_r8_wr_not_driving: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_wr |-> !md_oe);
  a_r1_strobes_exclusive: assert property (@(posedge mdc) disable iff (!rst_n)
    !(reg_rd && reg_wr));
endmodule

bind mgmt_serial_slave mgmt_serial_slave_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .mdc(mdc), .rst_n(rst_n), .md_out(md_out), .md_oe(md_oe),
  .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/tb_mgmt_serial_slave.sv
module tb_mgmt_serial_slave;
  localparam int NREG = 11;
  localparam logic [4:0] MYPHY = 5'b01001;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_n = ~MYPHY;
  logic        md_in = 1'b0;
  logic        md_out, md_oe, reg_rd, reg_wr;
  logic [4:0]  reg_addr;
  logic [15:0] reg_rdata, reg_wdata;
  logic [15:0] bank [NREG];
  int n_chk = 0, n_bad = 0;

  always #5 mdc = ~mdc;

  mgmt_serial_slave dut (
    .mdc(mdc), .rst_n(rst_n), .strap_n(strap_n), .md_in(md_in),
    .md_out(md_out), .md_oe(md_oe), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

  assign reg_rdata = (reg_rd && reg_addr < 5'(NREG)) ? bank[reg_addr[3:0]] : 16'hDEAD;
  always @(posedge mdc)
    if (reg_wr && reg_addr < 5'(NREG)) bank[reg_addr[3:0]] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input int pre, input logic [1:0] st, input logic rdf, input logic wrf,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d,
                       input logic [15:0] exp, input bit good, input string req);
    logic [31:0] bits;
    logic [15:0] got;
    bit bad_drive, bad_strobe, hit, rdok;
    bits = {st, rdf, wrf, phy, ra, 2'b10, d};
    got = '0; bad_drive = 0; bad_strobe = 0;
    hit = (ra < 5'(NREG));
    rdok = good && rdf;
    repeat (pre) begin @(negedge mdc); md_in = 1'b1; end
    for (int i = 0; i < 32; i++) begin
      @(negedge mdc);
      if (rdok) begin
        if (i == 14) begin
          chk(md_oe == 1'b0, "R6 first turnaround undriven", 32'(md_oe), 0);
          chk(reg_rd == hit, "R6 read strobe", 32'(reg_rd), 32'(hit));
          if (hit) chk(reg_addr == ra, "R6 read address", 32'(reg_addr), 32'(ra));
        end
        if (i == 15) chk(md_oe && !md_out, "R6 second turnaround zero", {md_oe, md_out}, 2'b10);
        if (i >= 16) begin
          if (!md_oe) bad_drive = 1;
          got = {got[14:0], md_out};
        end
      end else if (md_oe) bad_drive = 1;
      if (!(rdok && i == 14) && (reg_rd || reg_wr)) bad_strobe = 1;
      md_in = (rdok && i >= 14) ? 1'b1 : bits[31-i];
    end
    @(negedge mdc);
    chk(!md_oe, "R7 line released after frame", 32'(md_oe), 0);
    if (good && wrf) begin
      chk(reg_wr == hit, {req, " write strobe"}, 32'(reg_wr), 32'(hit));
      if (hit) begin
        chk(reg_addr == ra, "R8 write address", 32'(reg_addr), 32'(ra));
        chk(reg_wdata == d, "R8 write data", 32'(reg_wdata), 32'(d));
      end
    end else begin
      chk(!reg_wr, {req, " no write strobe"}, 32'(reg_wr), 0);
    end
    if (rdok) chk(got == exp, {req, " read data"}, 32'(got), 32'(exp));
    chk(!bad_drive, {req, " drive pattern"}, 32'(bad_drive), 0);
    chk(!bad_strobe, {req, " stray strobe"}, 32'(bad_strobe), 0);
  endtask

  // {is_write, reg address, write data, expected read data}
  localparam logic [37:0] VEC [8] = '{
    {1'b1, 5'd0,  16'h1234, 16'h0000},
    {1'b1, 5'd10, 16'hBEEF, 16'h0000},
    {1'b0, 5'd0,  16'h0000, 16'h1234},
    {1'b0, 5'd10, 16'h0000, 16'hBEEF},
    {1'b1, 5'd12, 16'hFFFF, 16'h0000},
    {1'b0, 5'd12, 16'h0000, 16'h0000},
    {1'b1, 5'd5,  16'hA55A, 16'h0000},
    {1'b0, 5'd5,  16'h0000, 16'hA55A}
  };

  initial begin
    for (int k = 0; k < NREG; k++) bank[k] = '0;
    repeat (3) @(negedge mdc);
    chk(!md_oe && !reg_rd && !reg_wr, "R1 reset outputs", {md_oe, reg_rd, reg_wr}, 0);
    rst_n = 1'b1;
    strap_n = 5'b00000;
    @(negedge mdc);
    chk(!md_oe && !reg_rd && !reg_wr, "R1 after reset", {md_oe, reg_rd, reg_wr}, 0);

    frame(31, 2'b01, 1'b0, 1'b1, MYPHY, 5'd2, 16'h0000, 16'h0000, 0, "R2 short preamble");

    for (int v = 0; v < 8; v++) begin
      logic [37:0] e;
      e = VEC[v];
      if (e[37]) frame(32, 2'b01, 1'b0, 1'b1, MYPHY, e[36:32], e[31:16], 16'h0, 1, "R8");
      else       frame(32, 2'b01, 1'b1, 1'b0, MYPHY, e[36:32], 16'h0, e[15:0], 1, "R7");
    end

    frame(32, 2'b00, 1'b0, 1'b1, MYPHY, 5'd1, 16'h7770, 16'h0, 0, "R3 bad start");
    frame(32, 2'b11, 1'b1, 1'b0, MYPHY, 5'd1, 16'h0000, 16'h0, 0, "R3 bad start read");
    frame(32, 2'b01, 1'b1, 1'b1, MYPHY, 5'd1, 16'h7770, 16'h0, 0, "R4 both flags");
    frame(32, 2'b01, 1'b0, 1'b0, MYPHY, 5'd1, 16'h7770, 16'h0, 0, "R4 no flags");
    frame(32, 2'b01, 1'b0, 1'b1, 5'b01000, 5'd1, 16'h7770, 16'h0, 0, "R5 wrong address");
    frame(32, 2'b01, 1'b1, 1'b0, ~5'b00000, 5'd1, 16'h0, 16'h0, 0, "R5 new strap value");
    frame(32, 2'b01, 1'b1, 1'b0, MYPHY, 5'd1, 16'h0, 16'h0000, 1, "R5 reg1 untouched");
    frame(32, 2'b01, 1'b1, 1'b0, MYPHY, 5'd2, 16'h0, 16'h0000, 1, "R2 reg2 untouched");

    frame(32, 2'b01, 1'b0, 1'b1, MYPHY, 5'd3, 16'h0F0F, 16'h0, 1, "R8");
    frame(0,  2'b01, 1'b0, 1'b1, MYPHY, 5'd3, 16'hF0F0, 16'h0, 0, "R9 no preamble");
    frame(32, 2'b01, 1'b1, 1'b0, MYPHY, 5'd3, 16'h0, 16'h0F0F, 1, "R9 readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule